// File: doc/BRIEF.md
# DDR2 Column Command Latency Scheduler

This controller-side timing unit models how a DDR2 memory device handles the additive latency of posted column commands and the CAS latency that follows. A load strobe captures two values: the extended mode word, whose three-bit field at bits [5:3] holds the additive latency code, and a separate CAS latency value. From then on, the unit accepts at most one READ or WRITE per clock. It marks the clock in which each command reaches the device's internal column logic. It then opens a data window for the burst: a read-data-valid window for a READ and a write-data-enable window for a WRITE.

Each window lasts half the burst length in clocks, because data moves on both clock edges. A beat index counts through the window. A shift pipeline as deep as the longest read latency holds every command still in flight, so closely spaced commands are never lost. A counter loaded on ACTIVE flags any column command that comes too early for the programmed additive latency to cover the activate-to-column delay.

Top module: `cas_latency_sched`

## Requirements
- R1: While `cfg_load` is high, the unit captures the additive latency code from `cfg_mode[5:3]` (legal values 0 to 4) and the CAS latency from `cfg_cas` (legal values 3 to 5). The other mode bits have no effect. After reset the settings are AL=0 and CL=3, and all outputs are low.
- R2: A load with an AL code of 5, 6 or 7, or with a CAS latency outside 3 to 5, sets `cfg_err` in the next cycle and leaves the previous settings in use. A legal load clears `cfg_err`. Outside a load, `cfg_err` keeps its value.
- R3: A column command in cycle n pulses `issue_rd` or `issue_wr` in cycle n+AL. When AL=0 the pulse comes in the same cycle as the command.
- R4: A READ in cycle n drives `rd_valid` high in cycles n+AL+CL through n+AL+CL+1. In those cycles `rd_beat` is 0 and then 1 (burst length 4 gives two clocks).
- R5: A WRITE in cycle n drives `wr_en` high in cycles n+AL+CL-1 through n+AL+CL. In those cycles `wr_beat` is 0 and then 1.
- R6: Two commands of the same kind two cycles apart produce one unbroken four-cycle window, and the beat index restarts at 0 for the second command. A command one cycle after another of the same kind cuts the earlier window short, and its own window starts at beat 0.
- R7: When `cmd_rd` and `cmd_wr` are both high in the same cycle, only the READ is taken. No write issue and no write window result from that cycle.
- R8: Let the latest ACTIVE be in cycle a (an ACTIVE in the same cycle as the column command counts as elapsed 0). A column command in cycle n with (n-a)+AL < TRCD raises `trcd_viol` in cycle n+1, for that one cycle. If no ACTIVE has occurred since reset, no violation is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture mode word and CAS latency |
| cfg_mode | input | 16 | Extended mode word; AL code in bits [5:3] |
| cfg_cas | input | 3 | CAS latency in clocks |
| cmd_act | input | 1 | ACTIVE command this cycle |
| cmd_rd | input | 1 | READ command this cycle |
| cmd_wr | input | 1 | WRITE command this cycle |
| cfg_err | output | 1 | Last load carried a reserved or out-of-range value |
| issue_rd | output | 1 | READ reaches the internal column logic |
| issue_wr | output | 1 | WRITE reaches the internal column logic |
| rd_valid | output | 1 | Read data window open |
| rd_beat | output | 1 | Clock index inside the read window |
| wr_en | output | 1 | Write data window open |
| wr_beat | output | 1 | Clock index inside the write window |
| trcd_viol | output | 1 | Previous column command came too early after ACTIVE |

## Verification
The read window and the write window can be open in the same cycle. A READ followed one clock later by a WRITE puts both windows on the same two cycles, because the write latency is one clock shorter. The bench runs this pairing at every legal AL/CL combination, and an arithmetic reference model, driven from a history of the commands sent, judges each cycle's valid, enable and beat values. The violation flag and a command issue can also fall in the same cycle. The bench pairs ACTIVE with reads at chosen gaps and checks that the flag appears only in the cycle after each early command.

// File: rtl/cas_sched_pkg.sv
package cas_sched_pkg;
  localparam int AL_MAX = 4;
  localparam int CL_MIN = 3;
  localparam int CL_MAX = 5;
  localparam int LAT_MAX = AL_MAX + CL_MAX;

  typedef struct packed {
    logic [2:0] al;
    logic [2:0] cl;
  } lat_cfg_t;
endpackage

// File: rtl/cas_cfg_reg.sv
module cas_cfg_reg
  import cas_sched_pkg::*;
#(
  parameter int EMR_W  = 16,
  parameter int AL_LSB = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EMR_W-1:0] mode,
  input  logic [2:0]       cas,
  output lat_cfg_t         cfg,
  output logic             err
);
  logic [2:0] al_code;
  logic       legal;
  lat_cfg_t   cfg_q, cfg_n;
  logic       err_q, err_n;

  always_comb begin
    al_code = mode[AL_LSB +: 3];
    legal   = (al_code <= 3'(AL_MAX)) && (cas >= 3'(CL_MIN)) && (cas <= 3'(CL_MAX));
    cfg_n   = cfg_q;
    err_n   = !legal;
    if (legal) begin
      cfg_n.al = al_code;
      cfg_n.cl = cas;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{al: 3'd0, cl: 3'(CL_MIN)};
      err_q <= 1'b0;
    end else if (load) begin
      cfg_q <= cfg_n;
      err_q <= err_n;
    end
  end

  assign cfg = cfg_q;
  assign err = err_q;
endmodule

// File: rtl/cas_trcd_chk.sv
module cas_trcd_chk #(
  parameter int TRCD  = 4,
  parameter int LAT_W = 4,
  localparam int RC_W = $clog2(TRCD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             col,
  input  logic [LAT_W-1:0] al,
  output logic             viol
);
  logic [RC_W-1:0] rem_q, rem_n, rem_eff;
  logic            viol_q, viol_n;

  always_comb begin
    rem_eff = act ? RC_W'(TRCD) : rem_q;
    viol_n  = col && (32'(rem_eff) > 32'(al));
    if (act)             rem_n = RC_W'(TRCD - 1);
    else if (rem_q != 0) rem_n = rem_q - RC_W'(1);
    else                 rem_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      viol_q <= viol_n;
    end
  end

  assign viol = viol_q;
endmodule

// File: rtl/cas_lat_pipe.sv
module cas_lat_pipe #(
  parameter int DEPTH = 9,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [LAT_W-1:0] al,
  input  logic [LAT_W-1:0] lat,
  output logic             issue,
  output logic             start
);
  logic [DEPTH-1:0] sr_q, sr_n;

  always_comb begin
    sr_n  = {sr_q[DEPTH-2:0], din};
    issue = (al == '0) ? din : sr_q[al - LAT_W'(1)];
    start = (lat == '0) ? 1'b0 : sr_q[lat - LAT_W'(1)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end
endmodule

// File: rtl/cas_burst_win.sv
module cas_burst_win #(
  parameter int BEATS  = 2,
  parameter int BEAT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              valid,
  output logic [BEAT_W-1:0] beat
);
  logic              act_q, act_n;
  logic [BEAT_W-1:0] beat_q, beat_n, cur;

  always_comb begin
    cur    = start ? '0 : beat_q;
    valid  = start | act_q;
    beat   = valid ? cur : '0;
    act_n  = 1'b0;
    beat_n = '0;
    if (valid && (cur != BEAT_W'(BEATS - 1))) begin
      act_n  = 1'b1;
      beat_n = cur + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
    end else begin
      act_q  <= act_n;
      beat_q <= beat_n;
    end
  end
endmodule

// File: rtl/cas_latency_sched.sv
module cas_latency_sched
  import cas_sched_pkg::*;
#(
  parameter int EMR_W     = 16,
  parameter int AL_LSB    = 3,
  parameter int BURST_LEN = 4,
  parameter int TRCD      = 4,
  localparam int BEATS    = BURST_LEN / 2,
  localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [EMR_W-1:0]  cfg_mode,
  input  logic [2:0]        cfg_cas,
  input  logic              cmd_act,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  output logic              cfg_err,
  output logic              issue_rd,
  output logic              issue_wr,
  output logic              rd_valid,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              wr_en,
  output logic [BEAT_W-1:0] wr_beat,
  output logic              trcd_viol
);
  localparam int DEPTH = LAT_MAX;
  localparam int LAT_W = $clog2(DEPTH + 1);

  lat_cfg_t         cfg;
  logic [LAT_W-1:0] al, rl, wl;
  logic             wr_take, rd_start, wr_start;

  always_comb begin
    al      = LAT_W'(cfg.al);
    rl      = al + LAT_W'(cfg.cl);
    wl      = rl - LAT_W'(1);
    wr_take = cmd_wr & ~cmd_rd;
  end

  cas_cfg_reg #(.EMR_W(EMR_W), .AL_LSB(AL_LSB)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .mode(cfg_mode), .cas(cfg_cas),
    .cfg(cfg), .err(cfg_err)
  );

  cas_trcd_chk #(.TRCD(TRCD), .LAT_W(LAT_W)) u_trcd (
    .clk(clk), .rst_n(rst_n), .act(cmd_act), .col(cmd_rd | cmd_wr), .al(al),
    .viol(trcd_viol)
  );

  cas_lat_pipe #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_rd_pipe (
    .clk(clk), .rst_n(rst_n), .din(cmd_rd), .al(al), .lat(rl),
    .issue(issue_rd), .start(rd_start)
  );

  cas_lat_pipe #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_wr_pipe (
    .clk(clk), .rst_n(rst_n), .din(wr_take), .al(al), .lat(wl),
    .issue(issue_wr), .start(wr_start)
  );

  cas_burst_win #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_rd_win (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .valid(rd_valid), .beat(rd_beat)
  );

  cas_burst_win #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_wr_win (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .valid(wr_en), .beat(wr_beat)
  );
endmodule

// File: rtl/cas_sched_chk.sv
module cas_sched_chk #(
  parameter int BEAT_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              cmd_rd,
  input logic              cmd_wr,
  input logic              cfg_err,
  input logic              issue_rd,
  input logic              issue_wr,
  input logic              rd_valid,
  input logic [BEAT_W-1:0] rd_beat,
  input logic              wr_en,
  input logic [BEAT_W-1:0] wr_beat,
  input logic              trcd_viol
);
  a_r2_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_err));

  a_r4_rd_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (rd_beat == '0));

  a_r5_wr_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> (wr_beat == '0));

  a_r7_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue_rd, issue_wr}));

  a_r8_viol_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    trcd_viol |-> $past(cmd_rd | cmd_wr));
endmodule

bind cas_latency_sched cas_sched_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
  .cfg_err(cfg_err), .issue_rd(issue_rd), .issue_wr(issue_wr), .rd_valid(rd_valid),
  .rd_beat(rd_beat), .wr_en(wr_en), .wr_beat(wr_beat), .trcd_viol(trcd_viol)
);

// File: tb/tb_cas_latency_sched.sv
`timescale 1ns/1ps
module tb_cas_latency_sched;
  localparam int BEATS = 2;
  localparam int TRCD  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_mode = '0;
  logic [2:0]  cfg_cas = '0;
  logic        cmd_act = 1'b0, cmd_rd = 1'b0, cmd_wr = 1'b0;
  logic        cfg_err, issue_rd, issue_wr, rd_valid, wr_en, trcd_viol;
  logic [0:0]  rd_beat, wr_beat;

  int nvec = 0, nfail = 0, cyc = 0;
  int exp_al = 0, exp_cl = 3;
  bit mon_on = 0, viol_free = 0;
  logic [15:0] hr = '0, hw = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cas_latency_sched #(.TRCD(TRCD)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_cas(cfg_cas),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cfg_err(cfg_err),
    .issue_rd(issue_rd), .issue_wr(issue_wr), .rd_valid(rd_valid), .rd_beat(rd_beat),
    .wr_en(wr_en), .wr_beat(wr_beat), .trcd_viol(trcd_viol)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // reference model: window membership from command history and AL/CL arithmetic
  always @(negedge clk) begin
    #1;
    begin
      logic [3:0] base;
      int rl, wl;
      bit ev; int eb; bit ew; int ewb;
      base = 4'(cyc);
      hr[base] = cmd_rd;
      hw[base] = cmd_wr & ~cmd_rd;
      if (mon_on) begin
        rl = exp_al + exp_cl; wl = rl - 1;
        ev = 0; eb = 0; ew = 0; ewb = 0;
        for (int d = rl + BEATS - 1; d >= rl; d--)
          if (hr[base - 4'(d)]) begin ev = 1; eb = d - rl; end
        for (int d = wl + BEATS - 1; d >= wl; d--)
          if (hw[base - 4'(d)]) begin ew = 1; ewb = d - wl; end
        chk(rd_valid == ev, "R4 rd_valid", int'(rd_valid), int'(ev));
        if (ev) chk(int'(rd_beat) == eb, "R6 rd_beat", int'(rd_beat), eb);
        chk(wr_en == ew, "R5 wr_en", int'(wr_en), int'(ew));
        if (ew) chk(int'(wr_beat) == ewb, "R6 wr_beat", int'(wr_beat), ewb);
        chk(issue_rd == hr[base - 4'(exp_al)], "R3 issue_rd", int'(issue_rd), int'(hr[base - 4'(exp_al)]));
        chk(issue_wr == hw[base - 4'(exp_al)], "R7 issue_wr", int'(issue_wr), int'(hw[base - 4'(exp_al)]));
        if (viol_free) chk(trcd_viol == 1'b0, "R8 no violation", int'(trcd_viol), 0);
      end
    end
  end

  task automatic step(bit a, bit r, bit w);
    @(negedge clk);
    cfg_load = 1'b0; cmd_act = a; cmd_rd = r; cmd_wr = w;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic load(int al, int cl);
    @(negedge clk);
    cmd_act = 0; cmd_rd = 0; cmd_wr = 0;
    cfg_load = 1'b1;
    cfg_mode = (16'hA5C7 & ~16'h0038) | 16'((al & 7) << 3);
    cfg_cas  = 3'(cl);
  endtask

  task automatic err_case(int al, int cl, bit exp);
    load(al, cl);
    step(0, 0, 0);
    #1 chk(cfg_err == exp, "R2 cfg_err after load", int'(cfg_err), int'(exp));
    idle(3);
    #1 chk(cfg_err == exp, "R2 cfg_err held", int'(cfg_err), int'(exp));
  endtask

  task automatic trcd_case(int al, int gap, bit exp);
    load(al, 3);
    idle(12);
    exp_al = al; exp_cl = 3;
    if (gap == 0) step(1, 1, 0);
    else begin
      step(1, 0, 0);
      idle(gap - 1);
      step(0, 1, 0);
    end
    step(0, 0, 0);
    #1 chk(trcd_viol == exp, "R8 violation flag", int'(trcd_viol), int'(exp));
    step(0, 0, 0);
    #1 chk(trcd_viol == 1'b0, "R8 one-cycle pulse", int'(trcd_viol), 0);
    idle(12);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk({cfg_err, issue_rd, issue_wr, rd_valid, wr_en, trcd_viol} == 6'b0, "R1 reset outputs",
        int'({cfg_err, issue_rd, issue_wr, rd_valid, wr_en, trcd_viol}), 0);
    mon_on = 1; viol_free = 1;
    // R1 default AL=0 CL=3 timing
    step(0, 1, 0); idle(12);
    step(0, 0, 1); idle(12);
    // R3 R4 R5 R6 R7 sweep over all legal AL/CL settings
    for (int al = 0; al <= 4; al++) begin
      for (int cl = 3; cl <= 5; cl++) begin
        load(al, cl);
        idle(12);
        exp_al = al; exp_cl = cl;
        step(0, 1, 0); idle(12);
        step(0, 0, 1); idle(12);
        step(0, 1, 0); step(0, 0, 0); step(0, 1, 0); idle(12);
        step(0, 0, 1); step(0, 0, 0); step(0, 0, 1); idle(12);
        step(0, 1, 0); step(0, 0, 1); idle(12);
        step(0, 1, 1); idle(12);
        step(0, 1, 0); step(0, 1, 0); idle(12);
        step(0, 0, 1); step(0, 0, 1); idle(12);
      end
    end
    // R2 reserved codes and out-of-range CAS leave AL=4 CL=5 in use
    err_case(5, 3, 1'b1);
    step(0, 1, 0); idle(12);
    err_case(7, 4, 1'b1);
    err_case(2, 2, 1'b1);
    err_case(1, 6, 1'b1);
    step(0, 0, 1); idle(12);
    err_case(1, 4, 1'b0);
    idle(10);
    exp_al = 1; exp_cl = 4;
    step(0, 1, 0); idle(12);
    // R8 activate-to-column spacing
    viol_free = 0;
    trcd_case(0, 2, 1'b1);
    trcd_case(0, 3, 1'b1);
    trcd_case(0, 4, 1'b0);
    trcd_case(2, 1, 1'b1);
    trcd_case(2, 2, 1'b0);
    trcd_case(3, 0, 1'b1);
    trcd_case(4, 0, 1'b0);
    trcd_case(4, 1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule